// File: doc/BRIEF.md
# Serial Block-Write Configuration Slave

This block is the receive side of a two-wire serial bus that holds the control bits of a clock generator. A bus master loads them with a single block-write transaction. The transaction carries the slave address, a command byte, a byte count and then the data bytes. The data bytes always land in configuration slot 0 first, then slot 1, and so on upward. The block never sends data back. It only pulls the data line low to acknowledge a byte.

SCLK and SDATA are first brought into the system clock domain through two-flop synchronizers. A bus engine then finds START and STOP conditions, shifts in bytes and decides whether each byte is acknowledged. A small register bank holds the control fields and their reset values.

The control fields are:
- one enable bit per clock output (active high, 1 = running);
- a spread-spectrum enable;
- a selector for the function of a shared power-down/tristate pin;
- a memory-clock 133 MHz mode bit.

Top module: `sbw_cfg_slave`

## Requirements
- R1: After reset, the outputs are:
  - ssc_en_o=0, dot_en_o=1, usb_en_o=1;
  - mclk_en_o=13'h1FFF, agp_en_o=1;
  - pci_en_o=4'hF, pin_pd_sel_o=1, mclk133_o=0.
- R2: An address byte of 8'hD2 (write bit included) is acknowledged. Any other address byte, including 8'hD3 and 8'hD0, gets no acknowledge. The rest of that transaction changes no output.
- R3: The command byte and the count byte are acknowledged and never stored. The first data byte goes to slot 0, and each later one goes to the next slot.
- R4: A count byte of 0, or one above 32, is not acknowledged. No data of that transaction is stored.
- R5: A STOP after any whole data byte ends the transfer. Slots that were not reached keep their earlier values.
- R6: Bytes are received MSB first. The fields sit at these positions:
  - Slot 0: bit 3 ssc, bit 2 dot, bit 1 usb.
  - Slot 1: bits 7..0 are mclk_en_o[7:0].
  - Slot 2: bit 7 agp, bits 6..2 are mclk_en_o[12:8], bit 1 is pci_en_o[0].
  - Slot 3: bit 1 pin_pd_sel, bit 0 mclk133.
  - Slot 4: bits 2..0 are pci_en_o[3:1].
- R7: Data bytes for slots 5 to 7, and bytes past slot 7 up to the count, are acknowledged and discarded. Reserved bits in slots 0 to 4 affect no output.
- R8: Once the counted data bytes have arrived, any further byte is not acknowledged and is not stored.
- R9: A START or STOP in the middle of a byte aborts the transaction. The partial byte is not stored.
- R10: A START at any point, including a repeated START, begins a new address phase.
- R11: sda_pull_o is asserted only in the acknowledge clock. It rises after the SCLK fall that ends the eighth bit, and it is released after the SCLK fall that ends the acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCLK |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | 1 = pull the data line low (acknowledge) |
| ssc_en_o | output | 1 | Spread-spectrum enable |
| dot_en_o | output | 1 | Dot clock output enable |
| usb_en_o | output | 1 | USB clock output enable |
| mclk_en_o | output | 13 | Memory clock output enables, bit n = clock n |
| agp_en_o | output | 1 | Graphics-port 66 MHz clock enable |
| pci_en_o | output | 4 | PCI clock enables; bit 0 = PCI1 up to bit 3 = PCI4 |
| pin_pd_sel_o | output | 1 | Shared pin function: 1 = power-down, 0 = tristate |
| mclk133_o | output | 1 | Memory clock 133 MHz mode enable |

## Verification
The hardest case to reach from the ports is a bus condition that falls inside a byte. This means a STOP or a repeated START after only a few of the eight SCLK pulses. The bench reaches it with a task that clocks out a chosen number of bits and then raises SCLK while moving SDATA. It then checks through the enable outputs that the abandoned byte left its slot untouched. A second hard case is the count boundary. The bench sends transfers with counts of 0 and 33, and a transfer with 10 bytes followed by an eleventh. These show acknowledge, discard and refusal at the exact byte where each begins.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_CNT,
    ST_DATA,
    ST_DONE
  } sbw_state_e;

  // reset value of each stored configuration slot
  function automatic logic [7:0] cfg_default(input int slot);
    case (slot)
      0:       return 8'h06;
      1:       return 8'hFF;
      2:       return 8'hFE;
      3:       return 8'h02;
      4:       return 8'h07;
      default: return 8'h00;
    endcase
  endfunction

  // bits of each slot that carry a real field
  function automatic logic [7:0] cfg_mask(input int slot);
    case (slot)
      0:       return 8'h0E;
      1:       return 8'hFF;
      2:       return 8'hFE;
      3:       return 8'h03;
      4:       return 8'h07;
      default: return 8'h00;
    endcase
  endfunction

  // legal block length check
  function automatic logic count_ok(input logic [7:0] cnt, input int max_cnt);
    return (cnt != 8'd0) && (int'(cnt) <= max_cnt);
  endfunction

endpackage

// File: rtl/sbw_sync.sv
module sbw_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/sbw_link.sv
module sbw_link
  import sbw_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR  = 8'hD2,
  parameter int         MAX_COUNT = 32,
  parameter int         NUM_SLOTS = 8,
  localparam int        IDX_W     = $clog2(NUM_SLOTS),
  localparam int        CNT_W     = $clog2(MAX_COUNT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             sda_pull
);

  logic       scl_q, sda_q;
  logic       scl_rise, scl_fall, start_det, stop_det;
  sbw_state_e state, nxt_state;
  logic       in_ack, ack_arm, ack_dec;
  logic [2:0] bit_cnt;
  logic [6:0] shreg;
  logic [CNT_W-1:0] remain, data_idx;
  logic       byte_done;
  logic [7:0] rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  assign rx_byte   = {shreg, sda_s};
  assign byte_done = scl_rise & ~in_ack & (state != ST_IDLE) & (bit_cnt == 3'd7);

  always_comb begin
    ack_dec   = 1'b0;
    nxt_state = ST_IDLE;
    case (state)
      ST_ADDR: begin
        ack_dec   = (rx_byte == DEV_ADDR);
        nxt_state = ack_dec ? ST_CMD : ST_IDLE;
      end
      ST_CMD: begin
        ack_dec   = 1'b1;
        nxt_state = ST_CNT;
      end
      ST_CNT: begin
        ack_dec   = count_ok(rx_byte, MAX_COUNT);
        nxt_state = ack_dec ? ST_DATA : ST_IDLE;
      end
      ST_DATA: begin
        ack_dec   = 1'b1;
        nxt_state = (remain == CNT_W'(1)) ? ST_DONE : ST_DATA;
      end
      default: begin
        ack_dec   = 1'b0;
        nxt_state = ST_IDLE;
      end
    endcase
  end

  assign wr_en   = byte_done && (state == ST_DATA) && (int'(data_idx) < NUM_SLOTS);
  assign wr_idx  = data_idx[IDX_W-1:0];
  assign wr_data = rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      in_ack   <= 1'b0;
      ack_arm  <= 1'b0;
      bit_cnt  <= '0;
      shreg    <= '0;
      remain   <= '0;
      data_idx <= '0;
      sda_pull <= 1'b0;
    end else if (start_det || stop_det) begin
      state    <= start_det ? ST_ADDR : ST_IDLE;
      in_ack   <= 1'b0;
      ack_arm  <= 1'b0;
      bit_cnt  <= '0;
      sda_pull <= 1'b0;
    end else begin
      if (byte_done) begin
        state   <= nxt_state;
        ack_arm <= ack_dec;
        bit_cnt <= '0;
        if (state == ST_CNT) begin
          remain   <= rx_byte[CNT_W-1:0];
          data_idx <= '0;
        end else if (state == ST_DATA) begin
          remain   <= remain - CNT_W'(1);
          data_idx <= data_idx + CNT_W'(1);
        end
      end else if (scl_rise && !in_ack && state != ST_IDLE) begin
        shreg   <= {shreg[5:0], sda_s};
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (scl_fall) begin
        if (ack_arm) begin
          sda_pull <= 1'b1;
          in_ack   <= 1'b1;
          ack_arm  <= 1'b0;
        end else if (in_ack) begin
          sda_pull <= 1'b0;
          in_ack   <= 1'b0;
        end
      end
    end
  end

  a_r11_pull_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(scl_fall));

  a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);

  a_r8_done_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |-> !wr_en);

  a_r4_remain_live: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) |-> (remain != '0));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !in_ack) |-> !sda_pull);

endmodule

// File: rtl/sbw_cfg_bank.sv
module sbw_cfg_bank
  import sbw_pkg::*;
#(
  parameter int  NUM_SLOTS = 8,
  parameter int  NUM_CFG   = 5,
  localparam int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [7:0]           wr_data,
  output logic [NUM_CFG*8-1:0] cfg_flat
);

  for (genvar s = 0; s < NUM_CFG; s++) begin : g_slot
    logic [7:0] val;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        val <= cfg_default(s) & cfg_mask(s);
      else if (wr_en && int'(wr_idx) == s)
        val <= wr_data & cfg_mask(s);
    end
    assign cfg_flat[s*8 +: 8] = val;
  end

  a_r5_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_flat));

endmodule

// File: rtl/sbw_cfg_slave.sv
module sbw_cfg_slave
  import sbw_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR    = 8'hD2,
  parameter int         MAX_COUNT   = 32,
  parameter int         NUM_SLOTS   = 8,
  parameter int         SYNC_STAGES = 2,
  localparam int        NUM_CFG     = 5,
  localparam int        IDX_W       = $clog2(NUM_SLOTS)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_pull_o,
  output logic        ssc_en_o,
  output logic        dot_en_o,
  output logic        usb_en_o,
  output logic [12:0] mclk_en_o,
  output logic        agp_en_o,
  output logic [3:0]  pci_en_o,
  output logic        pin_pd_sel_o,
  output logic        mclk133_o
);

  logic [1:0]             bus_s;
  logic                   wr_en;
  logic [IDX_W-1:0]       wr_idx;
  logic [7:0]             wr_data;
  logic [NUM_CFG*8-1:0]   cfg_flat;
  logic [7:0]             s0, s1, s2, s3, s4;

  sbw_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   (bus_s)
  );

  sbw_link #(.DEV_ADDR(DEV_ADDR), .MAX_COUNT(MAX_COUNT), .NUM_SLOTS(NUM_SLOTS)) link_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (bus_s[1]),
    .sda_s    (bus_s[0]),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .sda_pull (sda_pull_o)
  );

  sbw_cfg_bank #(.NUM_SLOTS(NUM_SLOTS), .NUM_CFG(NUM_CFG)) bank_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .cfg_flat (cfg_flat)
  );

  assign s0 = cfg_flat[7:0];
  assign s1 = cfg_flat[15:8];
  assign s2 = cfg_flat[23:16];
  assign s3 = cfg_flat[31:24];
  assign s4 = cfg_flat[39:32];

  assign ssc_en_o     = s0[3];
  assign dot_en_o     = s0[2];
  assign usb_en_o     = s0[1];
  assign mclk_en_o    = {s2[6:2], s1};
  assign agp_en_o     = s2[7];
  assign pci_en_o     = {s4[2:0], s2[1]};
  assign pin_pd_sel_o = s3[1];
  assign mclk133_o    = s3[0];

  logic unused_reserved;
  assign unused_reserved = ^{s0[7:4], s0[0], s2[0], s3[7:2], s4[7:3]};

endmodule

// File: tb/sbw_cfg_slave_tb_top.sv
module sbw_cfg_slave_tb_top;

  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_pull_o, ssc_en_o, dot_en_o, usb_en_o, agp_en_o, pin_pd_sel_o, mclk133_o;
  logic [12:0] mclk_en_o;
  logic [3:0]  pci_en_o;

  int total = 0;
  int bad = 0;
  logic [7:0] mdl [0:4];

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull_o;

  sbw_cfg_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull_o), .ssc_en_o(ssc_en_o), .dot_en_o(dot_en_o),
    .usb_en_o(usb_en_o), .mclk_en_o(mclk_en_o), .agp_en_o(agp_en_o),
    .pci_en_o(pci_en_o), .pin_pd_sel_o(pin_pd_sel_o), .mclk133_o(mclk133_o)
  );

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected outputs from the bench model of slots (field positions from R6)
  task automatic chk_cfg(input string tag);
    logic [31:0] e, a;
    e = 32'(mdl[0][3]);
    e = (e << 1) | 32'(mdl[0][2]);
    e = (e << 1) | 32'(mdl[0][1]);
    for (int i = 12; i >= 0; i--)
      e = (e << 1) | 32'((i < 8) ? mdl[1][i] : mdl[2][i - 6]);
    e = (e << 1) | 32'(mdl[2][7]);
    for (int i = 3; i >= 0; i--)
      e = (e << 1) | 32'((i == 0) ? mdl[2][1] : mdl[4][i - 1]);
    e = (e << 1) | 32'(mdl[3][1]);
    e = (e << 1) | 32'(mdl[3][0]);
    a = {9'd0, ssc_en_o, dot_en_o, usb_en_o, mclk_en_o, agp_en_o, pci_en_o, pin_pd_sel_o, mclk133_o};
    chk(a == e, tag, a, e);
  endtask

  task automatic do_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq(2);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq();
      scl_m = 1'b1; wq();
      chk(sda_pull_o == 1'b0, "R11 no pull during data bit", 32'(sda_pull_o), 0);
      wq();
      scl_m = 1'b0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    send_bits(b, 8);
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    acked = sda_pull_o;
    wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic head(input logic [7:0] cnt, output logic a0, output logic a1, output logic a2);
    do_start();
    send_byte(8'hD2, a0);
    send_byte(8'h00, a1);
    send_byte(cnt, a2);
  endtask

  task automatic model_wr(input int slot, input logic [7:0] v);
    logic [7:0] m [0:4];
    m[0] = 8'h0E; m[1] = 8'hFF; m[2] = 8'hFE; m[3] = 8'h03; m[4] = 8'h07;
    if (slot < 5) mdl[slot] = v & m[slot];
  endtask

  task automatic t_reset();
    mdl[0] = 8'h06; mdl[1] = 8'hFF; mdl[2] = 8'hFE; mdl[3] = 8'h02; mdl[4] = 8'h07;
    chk_cfg("R1 reset values");
    chk(sda_pull_o == 1'b0, "R1 no pull at reset", 32'(sda_pull_o), 0);
  endtask

  task automatic t_full_write();
    logic a0, a1, a2, ad;
    logic [7:0] d [0:4];
    d[0] = 8'h08; d[1] = 8'hA5; d[2] = 8'h5A; d[3] = 8'h01; d[4] = 8'h05;
    head(8'd5, a0, a1, a2);
    chk(a0, "R2 address D2 acked", 32'(a0), 1);
    chk(a1 && a2, "R3 command and count acked", {a1, a2}, 3);
    for (int i = 0; i < 5; i++) begin
      send_byte(d[i], ad);
      chk(ad, "R3 data byte acked", 32'(ad), 1);
      model_wr(i, d[i]);
    end
    do_stop();
    chk_cfg("R6 field layout after five bytes");
    chk(ssc_en_o == 1'b1 && mclk_en_o[7:0] == 8'hA5, "R6 MSB first slot0/slot1",
        {ssc_en_o, mclk_en_o[7:0]}, 32'h1A5);
  endtask

  task automatic t_bad_addr();
    logic a;
    do_start();
    send_byte(8'hD0, a);
    chk(!a, "R2 address D0 not acked", 32'(a), 0);
    send_byte(8'h00, a); send_byte(8'h01, a); send_byte(8'h00, a);
    chk(!a, "R2 bytes after bad address not acked", 32'(a), 0);
    do_stop();
    do_start();
    send_byte(8'hD3, a);
    chk(!a, "R2 address D3 not acked", 32'(a), 0);
    do_stop();
    chk_cfg("R2 no change after bad address");
  endtask

  task automatic t_counts();
    logic a0, a1, a2, a;
    head(8'd0, a0, a1, a2);
    chk(!a2, "R4 count 0 not acked", 32'(a2), 0);
    send_byte(8'h00, a);
    do_stop();
    chk_cfg("R4 count 0 stores nothing");
    head(8'd33, a0, a1, a2);
    chk(!a2, "R4 count 33 not acked", 32'(a2), 0);
    send_byte(8'h00, a);
    do_stop();
    chk_cfg("R4 count 33 stores nothing");
  endtask

  task automatic t_partial_stop();
    logic a0, a1, a2, a;
    head(8'd5, a0, a1, a2);
    send_byte(8'h02, a); model_wr(0, 8'h02);
    send_byte(8'h3C, a); model_wr(1, 8'h3C);
    do_stop();
    chk_cfg("R5 stop after two bytes keeps slots 2..4");
  endtask

  task automatic t_long();
    logic a0, a1, a2, a;
    logic all_ack = 1'b1;
    head(8'd10, a0, a1, a2);
    for (int i = 0; i < 10; i++) begin
      logic [7:0] v;
      v = (i == 0) ? 8'hFF : (i == 3) ? 8'hFE : 8'(8'h11 * i);
      send_byte(v, a);
      all_ack &= a;
      model_wr(i, v);
    end
    chk(all_ack, "R7 bytes to slots 5..9 acked", 32'(all_ack), 1);
    send_byte(8'h00, a);
    chk(!a, "R8 byte after count not acked", 32'(a), 0);
    do_stop();
    chk_cfg("R7 discard and reserved bits ignored; R8 extra not stored");
  endtask

  task automatic t_abort();
    logic a0, a1, a2, a;
    head(8'd3, a0, a1, a2);
    send_byte(8'h0A, a); model_wr(0, 8'h0A);
    send_bits(8'h00, 5);
    do_stop();
    chk_cfg("R9 stop mid-byte drops partial");
    head(8'd2, a0, a1, a2);
    send_bits(8'h00, 3);
    do_start();
    send_byte(8'hD2, a);
    chk(a, "R10 repeated start restarts address phase", 32'(a), 1);
    send_byte(8'h00, a); send_byte(8'd1, a);
    send_byte(8'h04, a); model_wr(0, 8'h04);
    do_stop();
    chk_cfg("R9 start mid-byte drops partial; R10 new write lands in slot 0");
  endtask

  task automatic t_ack_release();
    logic a0, a1, a2;
    head(8'd1, a0, a1, a2);
    wq();
    chk(sda_pull_o == 1'b0, "R11 pull released after ack clock", 32'(sda_pull_o), 0);
    do_stop();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wq();
    t_reset();
    t_full_write();
    t_bad_addr();
    t_counts();
    t_partial_stop();
    t_long();
    t_abort();
    t_ack_release();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule